// File: doc/BRIEF.md
# Paged 32-bit Register Access Bridge

This block lets a local host read and write 32-bit switch registers over a management bus that carries only 16-bit clause-22 transactions. Each host access becomes three transactions on a request/acknowledge link to an MDIO transaction engine. The first is a page-select write. After it the bridge waits a fixed settle interval. It then moves the two 16-bit halves of the register.

The register byte address is broken into three fields. The page number is address bits [17:9]. The PHY sub-address is bits [8:6]. The even register index is bits [5:2] placed above a zero bit. Reads fetch the lower half before the upper half. Writes send the upper half first by default. A configuration pin makes writes send the lower half first.

The host side is a valid/ready request channel with a response pulse. A request is taken on a clock edge where both `host_req_valid` and `host_req_ready` are high. `host_req_ready` stays low from acceptance until the response has been given, and any request offered during that time is dropped. The response channel has no back-pressure: `host_rsp_valid` is high for exactly one cycle, and the host must take it then.

Top module: `paged_reg_bridge`

## Requirements
- R1: After reset, `host_req_ready` is high, and both `mdio_req` and `host_rsp_valid` are low.
- R2: For a host byte address A, the register index is (A>>1)&0x1E, the sub-address is (A>>6)&0x7, and the page is (A>>9)&0x1FF. Address bits 0 and 1 and bits above 17 have no effect.
- R3: Every access starts with a write of the zero-extended page number to PHY 0x18, register 0.
- R4: After the page write is acknowledged, `mdio_req` stays low for exactly SETTLE_CYCLES cycles. The first data transaction is then requested.
- R5: Data transactions use PHY 0x10 OR sub-address. The lower 16 bits are at the register index, and the upper 16 bits are at the index plus one.
- R6: A read fetches the lower half and then the upper half. `host_rsp_rdata` returns {upper, lower}.
- R7: When `cfg_lo_first` is 0, a write sends the upper half first and the lower half second. `cfg_lo_first` is sampled only at acceptance, so a change to it during an access has no effect on that access.
- R8: When `cfg_lo_first` is 1 at acceptance, a write sends the lower half first.
- R9: While `mdio_req` is high and `mdio_ack` is low, the request and all its fields hold steady. Each cycle with `mdio_ack` high completes exactly one transaction.
- R10: `host_req_ready` is high only when the bridge is idle. A request offered while it is low causes no transaction and no response.
- R11: `host_rsp_valid` is high for one cycle, in the cycle after the last acknowledge, for both reads and writes. `host_req_ready` rises in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lo_first | input | 1 | Writes send the lower half first when 1 |
| host_req_valid | input | 1 | Host request offered |
| host_req_ready | output | 1 | Bridge idle and accepting |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | ADDR_W | Register byte address |
| host_req_wdata | input | 32 | Write data |
| host_rsp_valid | output | 1 | One-cycle completion pulse |
| host_rsp_rdata | output | 32 | Read result {upper, lower} |
| mdio_req | output | 1 | Transaction request to the engine |
| mdio_ack | input | 1 | Engine completes the current transaction |
| mdio_wr | output | 1 | 1 = write transaction |
| mdio_phy | output | 5 | PHY address |
| mdio_reg | output | 5 | Register number |
| mdio_wdata | output | 16 | Write data |
| mdio_rdata | input | 16 | Read data, valid with `mdio_ack` |

## Verification
The bench samples every output on the falling edge. An acceptance edge puts the page request on the bus at the next sample. The settle gap is counted as exactly SETTLE_CYCLES low samples of `mdio_req` between the page acknowledge and the first data request. The response pulse is expected one sample after the last acknowledge, and ready is expected one sample after that. The engine model logs each acknowledged transaction and acknowledges after a chosen latency, so the order, the fields and the response delay are compared against values computed from the address formulas, not from the design.

// File: rtl/paged_bridge_pkg.sv
package paged_bridge_pkg;
  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int PAGE_W  = 9;
  localparam int SUB_W   = 3;
  localparam logic [PHY_W-1:0] PAGE_PHY      = 5'h18;
  localparam logic [REG_W-1:0] PAGE_REG      = 5'h00;
  localparam logic [PHY_W-1:0] DATA_PHY_BASE = 5'h10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PAGE, ST_SETTLE, ST_XFER1, ST_XFER2, ST_DONE
  } bridge_state_t;
endpackage

// File: rtl/pbr_addr_split.sv
module pbr_addr_split
  import paged_bridge_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PAGE_W-1:0] page,
  output logic [SUB_W-1:0]  sub,
  output logic [REG_W-1:0]  idx
);
  logic [ADDR_W-1:0] half_addr;
  logic [ADDR_W-1:0] sub_addr;
  logic [ADDR_W-1:0] page_addr;

  always_comb begin
    half_addr = addr >> 1;
    sub_addr  = half_addr >> REG_W;
    page_addr = sub_addr >> SUB_W;
    idx  = half_addr[REG_W-1:0] & ~REG_W'(1);
    sub  = sub_addr[SUB_W-1:0];
    page = page_addr[PAGE_W-1:0];
  end

  initial begin
    assert (ADDR_W >= 1 + REG_W + SUB_W + PAGE_W)
      else $error("address too narrow for page field");
  end
endmodule

// File: rtl/pbr_settle_timer.sv
module pbr_settle_timer #(
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  assert_timer_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/pbr_half_sel.sv
module pbr_half_sel
  import paged_bridge_pkg::*;
(
  input  logic              second,
  input  logic              hi_first,
  input  logic [REG_W-1:0]  idx,
  input  logic [WORD_W-1:0] word,
  output logic [REG_W-1:0]  reg_num,
  output logic [HALF_W-1:0] half_data
);
  logic take_hi;

  always_comb begin
    take_hi   = second ^ hi_first;
    reg_num   = idx | {{(REG_W-1){1'b0}}, take_hi};
    half_data = take_hi ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
  end
endmodule

// File: rtl/paged_reg_bridge.sv
module paged_reg_bridge
  import paged_bridge_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int SETTLE_CYCLES = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lo_first,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [ADDR_W-1:0] host_req_addr,
  input  logic [31:0]       host_req_wdata,
  output logic              host_rsp_valid,
  output logic [31:0]       host_rsp_rdata,
  output logic              mdio_req,
  input  logic              mdio_ack,
  output logic              mdio_wr,
  output logic [4:0]        mdio_phy,
  output logic [4:0]        mdio_reg,
  output logic [15:0]       mdio_wdata,
  input  logic [15:0]       mdio_rdata
);
  bridge_state_t state, state_nx;

  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic              lofirst_q;
  logic [WORD_W-1:0] wdata_q;
  logic [HALF_W-1:0] lo_q, hi_q;

  logic [PAGE_W-1:0] page;
  logic [SUB_W-1:0]  sub;
  logic [REG_W-1:0]  idx;
  logic [REG_W-1:0]  half_reg;
  logic [HALF_W-1:0] half_data;
  logic              settle_done;
  logic              accept;

  pbr_addr_split #(.ADDR_W(ADDR_W)) u_split (
    .addr(addr_q), .page(page), .sub(sub), .idx(idx)
  );

  pbr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SETTLE), .expired(settle_done)
  );

  pbr_half_sel u_half (
    .second(state == ST_XFER2), .hi_first(wr_q && !lofirst_q),
    .idx(idx), .word(wdata_q), .reg_num(half_reg), .half_data(half_data)
  );

  assign host_req_ready = (state == ST_IDLE);
  assign accept         = host_req_valid && host_req_ready;
  assign host_rsp_valid = (state == ST_DONE);
  assign host_rsp_rdata = {hi_q, lo_q};

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (accept)      state_nx = ST_PAGE;
      ST_PAGE:   if (mdio_ack)    state_nx = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_nx = ST_XFER1;
      ST_XFER1:  if (mdio_ack)    state_nx = ST_XFER2;
      ST_XFER2:  if (mdio_ack)    state_nx = ST_DONE;
      ST_DONE:                    state_nx = ST_IDLE;
      default:                    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wr_q      <= 1'b0;
      lofirst_q <= 1'b0;
      wdata_q   <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
    end else begin
      if (accept) begin
        addr_q    <= host_req_addr;
        wr_q      <= host_req_write;
        lofirst_q <= cfg_lo_first;
        wdata_q   <= host_req_wdata;
      end
      if (mdio_ack && !wr_q && state == ST_XFER1) lo_q <= mdio_rdata;
      if (mdio_ack && !wr_q && state == ST_XFER2) hi_q <= mdio_rdata;
    end
  end

  always_comb begin
    mdio_req   = 1'b0;
    mdio_wr    = 1'b0;
    mdio_phy   = '0;
    mdio_reg   = '0;
    mdio_wdata = '0;
    case (state)
      ST_PAGE: begin
        mdio_req   = 1'b1;
        mdio_wr    = 1'b1;
        mdio_phy   = PAGE_PHY;
        mdio_reg   = PAGE_REG;
        mdio_wdata = HALF_W'(page);
      end
      ST_XFER1, ST_XFER2: begin
        mdio_req   = 1'b1;
        mdio_wr    = wr_q;
        mdio_phy   = DATA_PHY_BASE | PHY_W'(sub);
        mdio_reg   = half_reg;
        mdio_wdata = half_data;
      end
      default: ;
    endcase
  end

  assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_phy) && $stable(mdio_reg)
                                 && $stable(mdio_wr) && $stable(mdio_wdata)));

  assert_page_is_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_phy == PAGE_PHY) |-> (mdio_wr && mdio_reg == PAGE_REG));

  assert_data_phy_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_phy != PAGE_PHY) |-> (mdio_phy[4:3] == 2'b10));

  assert_rsp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |=> (!host_rsp_valid && host_req_ready));

  assert_no_bus_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_ready |-> (!mdio_req && !host_rsp_valid));

  assert_accept_goes_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req_valid && host_req_ready) |=> (!host_req_ready && mdio_req));
endmodule

// File: tb/paged_reg_bridge_tb.sv
module paged_reg_bridge_tb;
  localparam int SETTLE = 12;
  localparam int LIMIT  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_lo_first = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic [31:0] host_req_addr = '0;
  logic [31:0] host_req_wdata = '0;
  logic        host_rsp_valid;
  logic [31:0] host_rsp_rdata;
  logic        mdio_req, mdio_ack, mdio_wr;
  logic [4:0]  mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata, mdio_rdata;

  paged_reg_bridge #(.ADDR_W(32), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_lo_first(cfg_lo_first),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .host_req_write(host_req_write), .host_req_addr(host_req_addr),
    .host_req_wdata(host_req_wdata), .host_rsp_valid(host_rsp_valid),
    .host_rsp_rdata(host_rsp_rdata), .mdio_req(mdio_req), .mdio_ack(mdio_ack),
    .mdio_wr(mdio_wr), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_wdata(mdio_wdata), .mdio_rdata(mdio_rdata)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // engine model
  logic [15:0] mem [0:1023];
  logic [4:0]  log_phy [0:15];
  logic [4:0]  log_reg [0:15];
  logic        log_wr  [0:15];
  logic [15:0] log_dat [0:15];
  int log_n = 0, lat = 0, wait_cnt = 0;
  logic ack_r = 1'b0;
  logic [15:0] rd_r = '0;
  assign mdio_ack = ack_r;
  assign mdio_rdata = rd_r;

  always @(posedge clk) begin
    cyc = cyc + 1;
    ack_r <= 1'b0;
    if (mdio_req && !ack_r) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        ack_r <= 1'b1;
        rd_r <= mem[{mdio_phy, mdio_reg}];
        if (mdio_wr) mem[{mdio_phy, mdio_reg}] = mdio_wdata;
        if (log_n < 16) begin
          log_phy[log_n] = mdio_phy; log_reg[log_n] = mdio_reg;
          log_wr[log_n] = mdio_wr;   log_dat[log_n] = mdio_wdata;
        end
        log_n = log_n + 1;
      end else wait_cnt = wait_cnt + 1;
    end
  end

  // monitor
  int gap = 0, last_gap = -1, last_ack_cyc = 0, rsp_cyc = 0, rsp_cnt = 0;
  bit measuring = 0;
  always @(negedge clk) begin
    if (measuring) begin
      if (!mdio_req) gap = gap + 1;
      else begin measuring = 0; last_gap = gap; end
    end
    if (mdio_ack) begin
      last_ack_cyc = cyc;
      if (mdio_phy == 5'h18) begin measuring = 1; gap = 0; end
    end
    if (host_rsp_valid) begin rsp_cnt = rsp_cnt + 1; rsp_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] f_idx(input logic [31:0] a);  return 5'((a >> 1) & 32'h1e); endfunction
  function automatic logic [2:0] f_sub(input logic [31:0] a);  return 3'((a >> 6) & 32'h7); endfunction
  function automatic logic [8:0] f_page(input logic [31:0] a); return 9'((a >> 9) & 32'h1ff); endfunction

  // one access; returns read data
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input bit lof, input bit flip, input bit inject, output logic [31:0] rd);
    int t = 0;
    @(negedge clk); #1;
    log_n = 0; rsp_cnt = 0; last_gap = -1;
    cfg_lo_first = lof; host_req_write = wr; host_req_addr = a; host_req_wdata = wd;
    chk(host_req_ready, "R10 ready when idle", {31'b0, host_req_ready}, 32'h1);
    host_req_valid = 1'b1;
    @(negedge clk); #1;
    host_req_valid = 1'b0;
    if (flip) cfg_lo_first = !lof;
    if (inject) begin
      chk(!host_req_ready, "R10 ready low while busy", {31'b0, host_req_ready}, 32'h0);
      host_req_valid = 1'b1; host_req_write = 1'b1; host_req_addr = 32'h0003_fffc;
      host_req_wdata = 32'hdead_beef;
      @(negedge clk); #1;
      host_req_valid = 1'b0;
    end
    while (rsp_cnt == 0 && t < 5000) begin @(negedge clk); #1; t++; end
    rd = host_rsp_rdata;
    chk(rsp_cyc - last_ack_cyc == 1, "R11 response one cycle after last ack", rsp_cyc - last_ack_cyc, 1);
    @(negedge clk); #1;
    chk(!host_rsp_valid && host_req_ready, "R11 pulse ends and ready returns",
        {30'b0, host_rsp_valid, host_req_ready}, 32'h1);
    chk(log_n == 3, "R9 three transactions per access", log_n, 3);
    chk(last_gap == SETTLE, "R4 settle gap", last_gap, SETTLE);
    chk(log_phy[0] == 5'h18 && log_reg[0] == 0 && log_wr[0], "R3 page target",
        {log_wr[0], log_phy[0], log_reg[0]}, {1'b1, 5'h18, 5'h0});
    chk(log_dat[0] == {7'b0, f_page(a)}, "R2 R3 page value", log_dat[0], {7'b0, f_page(a)});
    chk(log_phy[1] == (5'h10 | {2'b0, f_sub(a)}) && log_phy[2] == log_phy[1], "R5 data phy",
        log_phy[1], 5'h10 | {2'b0, f_sub(a)});
  endtask

  task automatic test_reset();
    @(negedge clk); #1;
    chk(host_req_ready && !mdio_req && !host_rsp_valid, "R1 reset state",
        {29'b0, host_req_ready, mdio_req, host_rsp_valid}, 32'h4);
  endtask

  task automatic test_read(input logic [31:0] a, input int latency);
    logic [31:0] rd, exp;
    lat = latency;
    exp = {mem[{5'h10 | {2'b0, f_sub(a)}, f_idx(a) | 5'd1}], mem[{5'h10 | {2'b0, f_sub(a)}, f_idx(a)}]};
    access(1'b0, a, 32'h0, 1'b0, 1'b0, 1'b0, rd);
    chk(!log_wr[1] && !log_wr[2] && log_reg[1] == f_idx(a) && log_reg[2] == (f_idx(a) | 5'd1),
        "R6 R5 read order low then high", {log_reg[1], log_reg[2]}, {f_idx(a), f_idx(a) | 5'd1});
    chk(rd == exp, "R6 read data", rd, exp);
  endtask

  task automatic test_write(input logic [31:0] a, input logic [31:0] wd, input bit lof, input bit flip, input string tag);
    logic [31:0] rd;
    logic [4:0]  r1, r2;
    logic [15:0] d1, d2;
    lat = 1;
    access(1'b1, a, wd, lof, flip, 1'b0, rd);
    r1 = lof ? f_idx(a) : (f_idx(a) | 5'd1);
    r2 = lof ? (f_idx(a) | 5'd1) : f_idx(a);
    d1 = lof ? wd[15:0] : wd[31:16];
    d2 = lof ? wd[31:16] : wd[15:0];
    chk(log_wr[1] && log_wr[2] && log_reg[1] == r1 && log_reg[2] == r2, {tag, " write order"},
        {log_reg[1], log_reg[2]}, {r1, r2});
    chk(log_dat[1] == d1 && log_dat[2] == d2, {tag, " write halves"},
        {log_dat[1], log_dat[2]}, {d1, d2});
  endtask

  task automatic test_busy_ignore();
    logic [31:0] rd;
    lat = 2;
    access(1'b0, 32'h0000_1234, 32'h0, 1'b0, 1'b0, 1'b1, rd);
    repeat (SETTLE + 10) @(negedge clk);
    #1;
    chk(log_n == 3 && rsp_cnt == 1, "R10 request while busy ignored", {log_n[15:0], rsp_cnt[15:0]}, {16'd3, 16'd1});
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 16'h0107 + 16'h3c5a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_read(32'h0003_a5e4, 0);
    test_read(32'hffff_ffff, 3);
    test_read(32'h0000_0002, 1);
    test_write(32'h0001_2348, 32'hcafe_f00d, 1'b0, 1'b0, "R7");
    test_write(32'h0002_4a90, 32'h1357_9bdf, 1'b1, 1'b0, "R8");
    test_write(32'h0000_0f1c, 32'h2468_ace0, 1'b0, 1'b1, "R7 sampled at accept");
    test_read(32'h0002_4a90, 2);
    chk(host_rsp_rdata == 32'h1357_9bdf, "R6 read back after write", host_rsp_rdata, 32'h1357_9bdf);
    test_busy_ignore();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > LIMIT && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule